// File: doc/BRIEF.md
# Microcontroller Reset Sequencer

This block produces the internal chip reset of a small microcontroller and reports to firmware why the last reset happened. It has four reset sources: a power-on detector (the block's own active-low synchronous reset), a brown-out detector that is gated by a configuration enable, an external reset pin, and a watchdog timeout. How a source acts depends on whether the core is asleep. Power-on and brown-out are power-up resets. After such a reset the chip stays in reset while a power-up timer counts a slow timebase and then while an oscillator start-up timer counts the main oscillator. Each timer can be bypassed by a configuration input. Pin and watchdog resets are non-power-up resets. They skip the power-up timer. A pin reset taken during sleep still waits for the oscillator start-up timer, because the oscillator was stopped while the core slept.

Both timebases come into the block as one-cycle strobes in the system clock domain. The external pin passes through a glitch filter, and only a low level that lasts long enough counts as a reset. A watchdog timeout during sleep does not reset anything. It gives a one-cycle wake pulse so that the core resumes. The cause register is one-hot and always holds exactly one bit.

Top module: `rst_sequencer`

## Requirements
- R1: While `rst_n` is low, `chip_rst` is high and `cause` is 6'b000001 (power-on). A power-on reset is a power-up reset.
- R2: After a power-up reset source clears, `chip_rst` stays high for 1024 `pwrt_tick` strobes and then for 1024 `osc_tick` strobes. With ticks present on every cycle it is high for exactly 2048 cycles after the source clears. With no strobes it stays high indefinitely.
- R3: When `pwrt_en` is low the power-up timer phase is skipped, and when `ost_en` is low the start-up timer phase is skipped. With both low, `chip_rst` falls one cycle after the source clears.
- R4: When `bor_en` is low, a low `bor_n` has no effect on `chip_rst` or `cause`. When `bor_en` is high, a low `bor_n` is a power-up reset: it sets `cause` to 6'b000010 and holds reset for as long as it is low, plus the timer phases.
- R5: A low level on `mclr_n` that lasts fewer than 4 consecutive clock samples is ignored. A low level of w ≥ 4 samples holds `chip_rst` high for exactly w−3 cycles when the core is awake.
- R6: A filtered pin reset while awake sets `cause` to 6'b000100 and runs neither timer.
- R7: A filtered pin reset while `sleeping` is high sets `cause` to 6'b001000. It runs only the start-up timer (when `ost_en` is high), even when `pwrt_en` is high.
- R8: A single-cycle `wdt_to` while awake and running holds `chip_rst` high for one cycle and sets `cause` to 6'b010000.
- R9: A `wdt_to` while sleeping and running leaves `chip_rst` low, gives one single-cycle `wake` pulse, and sets `cause` to 6'b100000.
- R10: While `chip_rst` is high, a pin reset or watchdog timeout leaves `cause` unchanged. A pin reset during the timer phases restarts the whole sequence, and a watchdog timeout then is ignored.
- R11: `cause` always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on detect, active low, synchronous |
| bor_en | input | 1 | Brown-out detection enable |
| bor_n | input | 1 | Brown-out detect, low while the supply is below threshold |
| mclr_n | input | 1 | External reset pin level, active low |
| wdt_to | input | 1 | Watchdog timeout strobe |
| sleeping | input | 1 | Core is in sleep |
| pwrt_en | input | 1 | Power-up timer enable |
| ost_en | input | 1 | Oscillator start-up timer enable |
| pwrt_tick | input | 1 | Slow timebase strobe |
| osc_tick | input | 1 | Main oscillator strobe |
| chip_rst | output | 1 | Internal chip reset, active high |
| wake | output | 1 | One-cycle wake pulse |
| cause | output | 6 | One-hot last reset cause: bit0 power-on, bit1 brown-out, bit2 pin awake, bit3 pin asleep, bit4 watchdog, bit5 watchdog wake |

## Verification
A corrupted sequencer state shows up directly as a wrong length for the `chip_rst` high time. Because of that, the bench counts the high cycles of every reset and compares the count with a value worked out from the pulse width and the timer enables. A wrong filter count moves the release by whole cycles, visible within a few cycles. A timer that runs on a stale count or misses the hand-off between its phases shifts the release by up to 1024 cycles. A cause register that is written on the wrong event differs from the expected one-hot code as soon as the reset ends.

// File: rtl/rstseq_pkg.sv
`timescale 1ns/1ps
// Shared types for the reset sequencer.
// Assumes: one system clock; all timebases arrive as strobes in that domain.
package rstseq_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HOLD = 2'd1,
        ST_PWRT = 2'd2,
        ST_OST  = 2'd3
    } seq_state_t;

    localparam int CAUSE_W       = 6;
    localparam int C_POR         = 0;
    localparam int C_BOR         = 1;
    localparam int C_PIN_AWAKE   = 2;
    localparam int C_PIN_ASLEEP  = 3;
    localparam int C_WDT_RST     = 4;
    localparam int C_WDT_WAKE    = 5;
endpackage

// File: rtl/mclr_filter.sv
`timescale 1ns/1ps
// Glitch filter for the external reset pin.
// Counts consecutive low samples and reports the pin as active once FILT_LEN
// have been seen; a single high sample clears it.
// Assumes: pin_n is already synchronous to clk.
module mclr_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_act
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(FILT_LEN);

    logic [CW-1:0] low_cnt;

    // Count low samples, saturating at FULL; clear on any high sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (pin_n) begin
            low_cnt <= '0;
        end else if (low_cnt != FULL) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign pin_act = (low_cnt == FULL);

    AST_FILT_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_act) |-> $past(!pin_n)); // R5
    AST_FILT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_n && pin_act) |=> !pin_act); // R5
endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
// Strobe-counting timeout of 2**CNT_W strobes.
// Counts only while run is high, clears while idle, and flags done on the
// strobe that completes the count.
// Assumes: run stays high until done is seen.
module tick_timer #(
    parameter int CNT_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    logic [CNT_W-1:0] cnt;

    // Advance on each strobe while running; hold zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && tick && (cnt == '1);

    AST_TMR_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (cnt == '0)); // R2
endmodule

// File: rtl/rst_sequencer.sv
`timescale 1ns/1ps
// Reset sequencer: merges power-on, brown-out, pin and watchdog sources into
// one chip reset and runs the power-up and oscillator start-up timeouts.
// Records the last cause in a one-hot register and turns a watchdog timeout
// during sleep into a wake pulse.
// Assumes: rst_n is the power-on detector; strobes are in the clk domain.
module rst_sequencer #(
    parameter int FILT_LEN = 4,
    parameter int PWRT_W   = 10,
    parameter int OST_W    = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bor_en,
    input  logic       bor_n,
    input  logic       mclr_n,
    input  logic       wdt_to,
    input  logic       sleeping,
    input  logic       pwrt_en,
    input  logic       ost_en,
    input  logic       pwrt_tick,
    input  logic       osc_tick,
    output logic       chip_rst,
    output logic       wake,
    output logic [5:0] cause
);
    import rstseq_pkg::*;

    seq_state_t state, after_hold, after_pwrt;
    logic need_pwrt, need_ost;
    logic pin_act, pwrt_done, ost_done;
    logic bor_act, in_run, wdt_rst, wdt_wake, src_act;

    mclr_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk(clk), .rst_n(rst_n), .pin_n(mclr_n), .pin_act(pin_act)
    );

    tick_timer #(.CNT_W(PWRT_W)) u_pwrt (
        .clk(clk), .rst_n(rst_n), .run(state == ST_PWRT),
        .tick(pwrt_tick), .done(pwrt_done)
    );

    tick_timer #(.CNT_W(OST_W)) u_ost (
        .clk(clk), .rst_n(rst_n), .run(state == ST_OST),
        .tick(osc_tick), .done(ost_done)
    );

    // Qualify each source with the enable and the sleep state.
    always_comb begin
        bor_act  = bor_en && !bor_n;
        in_run   = (state == ST_RUN);
        wdt_rst  = wdt_to && !sleeping && in_run;
        wdt_wake = wdt_to && sleeping && in_run;
        src_act  = bor_act || pin_act || wdt_rst;
    end

    // Pick the phase that follows the hold and the power-up timer.
    always_comb begin
        if (need_pwrt && pwrt_en)     after_hold = ST_PWRT;
        else if (need_ost && ost_en)  after_hold = ST_OST;
        else                          after_hold = ST_RUN;
        after_pwrt = (need_ost && ost_en) ? ST_OST : ST_RUN;
    end

    // Reset state: set by any source, cleared at the end of the timeouts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_HOLD;
            need_pwrt <= 1'b1;
            need_ost  <= 1'b1;
        end else if (src_act) begin
            state <= ST_HOLD;
            if (bor_act) begin
                need_pwrt <= 1'b1;
                need_ost  <= 1'b1;
            end else if (in_run) begin
                need_pwrt <= 1'b0;
                need_ost  <= pin_act && sleeping;
            end
        end else begin
            unique case (state)
                ST_HOLD: state <= after_hold;
                ST_PWRT: if (pwrt_done) state <= after_pwrt;
                ST_OST:  if (ost_done)  state <= ST_RUN;
                default: state <= ST_RUN;
            endcase
        end
    end

    // Record the cause; pin and watchdog only from the running state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause <= CAUSE_W'(1) << C_POR;
        end else if (bor_act) begin
            cause <= CAUSE_W'(1) << C_BOR;
        end else if (in_run && pin_act) begin
            cause <= CAUSE_W'(1) << (sleeping ? C_PIN_ASLEEP : C_PIN_AWAKE);
        end else if (in_run && wdt_to) begin
            cause <= CAUSE_W'(1) << (sleeping ? C_WDT_WAKE : C_WDT_RST);
        end
    end

    // One-cycle wake pulse for a watchdog timeout taken in sleep.
    always_ff @(posedge clk) begin
        if (!rst_n) wake <= 1'b0;
        else        wake <= wdt_wake && !bor_act && !pin_act;
    end

    assign chip_rst = (state != ST_RUN);

    AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cause) == 1); // R11
    AST_WDT_SLEEP_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && wdt_to && sleeping && !bor_act && !pin_act) |=> (!chip_rst && wake)); // R9
    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake); // R9
    AST_BOR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_rst && !bor_en && !pin_act && !wdt_to) |=> !chip_rst); // R4
    AST_WDT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_rst && $past(!chip_rst) && $past(wdt_rst) && !src_act) |=> !chip_rst); // R8
endmodule

// File: tb/rst_sequencer_tb.sv
`timescale 1ns/1ps
module rst_sequencer_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bor_en = 1'b0, bor_n = 1'b1, mclr_n = 1'b1, wdt_to = 1'b0, sleeping = 1'b0;
    logic pwrt_en = 1'b1, ost_en = 1'b1, pwrt_tick = 1'b1, osc_tick = 1'b1;
    logic chip_rst, wake;
    logic [5:0] cause;

    int total = 0, bad = 0;
    int hi_cnt = 0, wk_cnt = 0;
    int base, wbase;
    logic [5:0] exp_cause;
    bit finished = 0;

    localparam int T = 1024;

    always #4 clk = ~clk;

    rst_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .bor_en(bor_en), .bor_n(bor_n),
        .mclr_n(mclr_n), .wdt_to(wdt_to), .sleeping(sleeping),
        .pwrt_en(pwrt_en), .ost_en(ost_en), .pwrt_tick(pwrt_tick),
        .osc_tick(osc_tick), .chip_rst(chip_rst), .wake(wake), .cause(cause)
    );

    always @(negedge clk) begin
        if (chip_rst === 1'b1) hi_cnt++;
        if (wake === 1'b1) wk_cnt++;
    end

    task automatic chk(string req, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (chip_rst === 1'b0) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic check_cause(string req);
        chk(req, int'(cause), int'(exp_cause));
        chk("R11", $countones(cause), 1);
    endtask

    task automatic por(int lows);
        rst_n = 1'b0;
        repeat (lows) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", int'(chip_rst), 1);
        chk("R1", int'(cause), 1);
        rst_n = 1'b1;
        settle();
        chk("R2", hi_cnt, 3 + 2 * T);
        exp_cause = 6'b000001;
        check_cause("R1");

        // R2/R3: enable combinations
        for (int c = 0; c < 4; c++) begin
            pwrt_en = c[0]; ost_en = c[1];
            base = hi_cnt;
            por(3);
            settle();
            chk("R3", hi_cnt - base, 3 + c[0] * T + c[1] * T);
            check_cause("R1");
        end
        pwrt_en = 1'b1; ost_en = 1'b1;

        // R2: no strobes, reset held
        pwrt_tick = 1'b0; osc_tick = 1'b0;
        por(3);
        repeat (200) @(negedge clk);
        chk("R2", int'(chip_rst), 1);
        pwrt_tick = 1'b1; osc_tick = 1'b1;
        settle();
        chk("R2", int'(chip_rst), 0);

        // R5/R6: pin pulse width sweep while awake
        for (int w = 1; w <= 8; w++) begin
            base = hi_cnt;
            mclr_n = 1'b0;
            repeat (w) @(negedge clk);
            mclr_n = 1'b1;
            repeat (3) @(negedge clk);
            settle();
            chk("R5", hi_cnt - base, (w >= 4) ? w - 3 : 0);
            if (w >= 4) exp_cause = 6'b000100;
            check_cause("R6");
        end

        // R7: pin reset in sleep, start-up timer only
        for (int o = 0; o < 2; o++) begin
            for (int w = 3; w <= 6; w++) begin
                ost_en = o[0];
                sleeping = 1'b1;
                base = hi_cnt;
                mclr_n = 1'b0;
                repeat (w) @(negedge clk);
                mclr_n = 1'b1;
                repeat (3) @(negedge clk);
                settle();
                sleeping = 1'b0;
                chk("R7", hi_cnt - base, (w >= 4) ? w - 3 + o * T : 0);
                if (w >= 4) exp_cause = 6'b001000;
                check_cause("R7");
            end
        end
        ost_en = 1'b1;

        // R8: watchdog reset while awake
        base = hi_cnt;
        wdt_to = 1'b1; @(negedge clk); wdt_to = 1'b0;
        settle();
        chk("R8", hi_cnt - base, 1);
        exp_cause = 6'b010000;
        check_cause("R8");

        // R9: watchdog in sleep wakes
        base = hi_cnt; wbase = wk_cnt;
        sleeping = 1'b1;
        wdt_to = 1'b1; @(negedge clk); wdt_to = 1'b0;
        repeat (4) @(negedge clk);
        sleeping = 1'b0;
        chk("R9", hi_cnt - base, 0);
        chk("R9", wk_cnt - wbase, 1);
        exp_cause = 6'b100000;
        check_cause("R9");

        // R4: brown-out gated, then enabled
        base = hi_cnt;
        bor_en = 1'b0; bor_n = 1'b0;
        repeat (10) @(negedge clk);
        bor_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R4", hi_cnt - base, 0);
        check_cause("R4");
        bor_en = 1'b1;
        base = hi_cnt;
        bor_n = 1'b0;
        repeat (5) @(negedge clk);
        bor_n = 1'b1;
        settle();
        chk("R4", hi_cnt - base, 5 + 2 * T);
        exp_cause = 6'b000010;
        check_cause("R4");
        bor_en = 1'b0;

        // R10: pin during timer restarts, cause kept
        base = hi_cnt;
        por(3);
        repeat (10) @(negedge clk);
        mclr_n = 1'b0;
        repeat (6) @(negedge clk);
        mclr_n = 1'b1;
        settle();
        chk("R10", hi_cnt - base, 3 + 10 + 6 + 1 + 2 * T);
        exp_cause = 6'b000001;
        check_cause("R10");

        // R10: watchdog during timer ignored
        base = hi_cnt;
        por(3);
        repeat (5) @(negedge clk);
        wdt_to = 1'b1; @(negedge clk); wdt_to = 1'b0;
        settle();
        chk("R10", hi_cnt - base, 3 + 2 * T);
        check_cause("R10");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1200000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule